// File: doc/BRIEF.md
# Bidirectional recirculating shift register

A chain of 32 one-bit stages that advances by one position on each rising clock edge. A direction input picks whether data travels toward the high end (stage 32) or toward the low end (stage 1). Each end has its own serial data input. When the rotate option is chosen, the serial inputs are ignored and the bit that falls off one end wraps around into the opposite end, so the contents circulate. A hold input freezes every stage. The direction, load-or-rotate and hold inputs are sampled on the rising edge and must stay steady while the clock is high.

Two serial taps show stage 1 and stage 32. These taps are re-timed on the falling clock edge, so a value captured at a rising edge appears at the taps half a cycle later. A synchronous reset for test clears the chain. A 32-bit observation bus shows every stage, with stage 1 on bit 0. Pushing bits in from one side and then reversing the direction makes the block behave as a last-in first-out stack that is read at the same side.

Top module: `shreg_bidir_rot`

## Requirements
- R1: With `rst` high at a rising edge, all stages become 0 even when `hold` is high. Both taps read 0 from the following falling edge on.
- R2: With `hold`=0, `load`=1 and `dir_dn`=0, a rising edge moves stage k into stage k+1 and loads `ser_up_i` into stage 1.
- R3: With `hold`=0, `load`=1 and `dir_dn`=1, a rising edge moves stage k+1 into stage k and loads `ser_dn_i` into stage 32.
- R4: With `hold`=0, `load`=0 and `dir_dn`=0, a rising edge rotates toward stage 32: the old stage 32 enters stage 1, and `ser_up_i` has no effect.
- R5: With `hold`=0, `load`=0 and `dir_dn`=1, a rising edge rotates toward stage 1: the old stage 1 enters stage 32, and `ser_dn_i` has no effect.
- R6: With `hold`=1 and `rst`=0 at a rising edge, no stage changes, whatever `dir_dn`, `load` and the serial inputs are.
- R7: `lo_tap_o` shows stage 1 and `hi_tap_o` shows stage 32. Each takes its new value only at a falling edge, and between a rising edge and the next falling edge it keeps the value it had before.
- R8: `stages_o` bit k-1 holds stage k, for k from 1 to 32, and it changes right after each rising edge.
- R9: `dir_dn`, `load` and `hold` must not change while `clk` is high. A simulation-only check flags any such change. The check does not alter the logic.
- R10: After 16 bits are pushed with R2 and the direction is then reversed with R3, `lo_tap_o` returns the pushed bits newest first, one per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; stages capture on the rising edge, taps on the falling edge |
| rst | input | 1 | Synchronous active-high reset |
| dir_dn | input | 1 | 0: move toward stage 32; 1: move toward stage 1 |
| load | input | 1 | 1: take the serial input at the entry end; 0: rotate |
| hold | input | 1 | 1: freeze all stages |
| ser_up_i | input | 1 | Serial bit that enters stage 1 when moving toward stage 32 |
| ser_dn_i | input | 1 | Serial bit that enters stage 32 when moving toward stage 1 |
| lo_tap_o | output | 1 | Stage 1, re-timed on the falling edge |
| hi_tap_o | output | 1 | Stage 32, re-timed on the falling edge |
| stages_o | output | 32 | All stages; stage 1 on bit 0 |

## Verification
The case that is hardest to reach from the ports is a tap that holds a stale value for the first half of a cycle while the chain has already moved. To reach it, the bench samples the taps after each rising edge and again after each falling edge, and a long sweep over every combination of controls and serial bits makes both end stages change often. Rotation only shows its wrap-around once the chain holds non-uniform data, so the sweep feeds the chain from a pseudo-random serial source before and between the rotate cycles, and it drives serial bits that disagree with the rotated bit. The stack order is checked by a dedicated push and reverse sequence that starts from a cleared chain.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

    // Kind of move taken at a rising edge
    typedef enum logic [2:0] {
        MV_HOLD   = 3'd0,
        MV_UP_SER = 3'd1,
        MV_DN_SER = 3'd2,
        MV_UP_ROT = 3'd3,
        MV_DN_ROT = 3'd4
    } move_e;

    // Falling-edge tap registers
    typedef struct packed {
        logic lo;
        logic hi;
    } tap_t;

endpackage

// File: rtl/shreg_mode_dec.sv
module shreg_mode_dec
    import shreg_pkg::*;
(
    input  logic  dir_dn_i,
    input  logic  load_i,
    input  logic  hold_i,
    output move_e move_o
);

    always_comb begin
        if (hold_i) begin
            move_o = MV_HOLD;
        end else if (load_i) begin
            move_o = dir_dn_i ? MV_DN_SER : MV_UP_SER;
        end else begin
            move_o = dir_dn_i ? MV_DN_ROT : MV_UP_ROT;
        end
    end

endmodule

// File: rtl/shreg_step.sv
module shreg_step
    import shreg_pkg::*;
#(
    parameter int STAGES = 32
) (
    input  logic [STAGES-1:0] cells_i,
    input  move_e             move_i,
    input  logic              ser_up_i,
    input  logic              ser_dn_i,
    output logic [STAGES-1:0] cells_o
);

    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] up_v;
    logic [STAGES-1:0] dn_v;
    logic              up_fill;
    logic              dn_fill;

    // The entry bit is either the serial input or the bit leaving the far end
    always_comb begin
        up_fill = (move_i == MV_UP_SER) ? ser_up_i : cells_i[TOP];
        dn_fill = (move_i == MV_DN_SER) ? ser_dn_i : cells_i[0];
    end

    for (genvar gi = 0; gi < STAGES; gi++) begin : g_cell
        if (gi == 0) begin : g_lo_end
            assign up_v[gi] = up_fill;
        end else begin : g_lo_mid
            assign up_v[gi] = cells_i[gi-1];
        end
        if (gi == TOP) begin : g_hi_end
            assign dn_v[gi] = dn_fill;
        end else begin : g_hi_mid
            assign dn_v[gi] = cells_i[gi+1];
        end
    end

    always_comb begin
        unique case (move_i)
            MV_UP_SER, MV_UP_ROT: cells_o = up_v;
            MV_DN_SER, MV_DN_ROT: cells_o = dn_v;
            default:              cells_o = cells_i;
        endcase
    end

endmodule

// File: rtl/shreg_edge_out.sv
module shreg_edge_out
    import shreg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lo_cell_i,
    input  logic hi_cell_i,
    output logic lo_tap_o,
    output logic hi_tap_o
);

    tap_t tap_d;
    tap_t tap_q;

    always_comb begin
        if (rst) begin
            tap_d = '0;
        end else begin
            tap_d.lo = lo_cell_i;
            tap_d.hi = hi_cell_i;
        end
    end

    always_ff @(negedge clk) begin
        tap_q <= tap_d;
    end

    assign lo_tap_o = tap_q.lo;
    assign hi_tap_o = tap_q.hi;

    // R7
    lo_tap_follow_chk: assert property (@(negedge clk) disable iff (rst)
        (tap_q.lo != lo_cell_i) |=> (tap_q.lo == $past(lo_cell_i)));

    // R7
    hi_tap_follow_chk: assert property (@(negedge clk) disable iff (rst)
        (tap_q.hi != hi_cell_i) |=> (tap_q.hi == $past(hi_cell_i)));

endmodule

// File: rtl/shreg_bidir_rot.sv
module shreg_bidir_rot
    import shreg_pkg::*;
#(
    parameter int STAGES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dir_dn,
    input  logic              load,
    input  logic              hold,
    input  logic              ser_up_i,
    input  logic              ser_dn_i,
    output logic              lo_tap_o,
    output logic              hi_tap_o,
    output logic [STAGES-1:0] stages_o
);

    localparam int TOP = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] cells;
    } core_t;

    core_t             core_d;
    core_t             core_q;
    move_e             move;
    logic [STAGES-1:0] step_cells;

    shreg_mode_dec u_dec (
        .dir_dn_i (dir_dn),
        .load_i   (load),
        .hold_i   (hold),
        .move_o   (move)
    );

    shreg_step #(.STAGES(STAGES)) u_step (
        .cells_i  (core_q.cells),
        .move_i   (move),
        .ser_up_i (ser_up_i),
        .ser_dn_i (ser_dn_i),
        .cells_o  (step_cells)
    );

    // Reset wins over hold and over every move
    always_comb begin
        core_d = core_q;
        if (rst) begin
            core_d.cells = '0;
        end else begin
            core_d.cells = step_cells;
        end
    end

    always_ff @(posedge clk) begin
        core_q <= core_d;
    end

    shreg_edge_out u_taps (
        .clk       (clk),
        .rst       (rst),
        .lo_cell_i (core_q.cells[0]),
        .hi_cell_i (core_q.cells[TOP]),
        .lo_tap_o  (lo_tap_o),
        .hi_tap_o  (hi_tap_o)
    );

    assign stages_o = core_q.cells;

    // Controls as seen at the last rising edge, for the steadiness check
    logic [2:0] ctrl_seen_q;
    always_ff @(posedge clk) begin
        ctrl_seen_q <= {dir_dn, load, hold};
    end

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (stages_o == '0));

    // R6
    hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(stages_o));

    // R2
    shift_up_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold && load && !dir_dn) |=>
        (stages_o == {$past(stages_o[TOP-1:0]), $past(ser_up_i)}));

    // R3
    shift_dn_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold && load && dir_dn) |=>
        (stages_o == {$past(ser_dn_i), $past(stages_o[TOP:1])}));

    // R4
    rot_up_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold && !load && !dir_dn) |=>
        (stages_o == {$past(stages_o[TOP-1:0]), $past(stages_o[TOP])}));

    // R5
    rot_dn_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold && !load && dir_dn) |=>
        (stages_o == {$past(stages_o[0]), $past(stages_o[TOP:1])}));

    // R9
    ctrl_steady_chk: assert property (@(negedge clk) disable iff (rst)
        ({dir_dn, load, hold} == ctrl_seen_q));

endmodule

// File: tb/shreg_bidir_rot_tb_top.sv
module shreg_bidir_rot_tb_top;

    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst, dir_dn, load, hold, ser_up_i, ser_dn_i;
    logic         lo_tap_o, hi_tap_o;
    logic [N-1:0] stages_o;

    int           total = 0;
    int           bad   = 0;
    logic [N-1:0] model;
    logic         lo_vis, hi_vis;
    bit           vis_ok = 1'b0;
    logic [15:0]  lfsr = 16'hACE1;

    always #5 clk = ~clk;

    shreg_bidir_rot #(.STAGES(N)) dut_i (
        .clk(clk), .rst(rst), .dir_dn(dir_dn), .load(load), .hold(hold),
        .ser_up_i(ser_up_i), .ser_dn_i(ser_dn_i),
        .lo_tap_o(lo_tap_o), .hi_tap_o(hi_tap_o), .stages_o(stages_o)
    );

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic r, input logic d, input logic l, input logic h);
        if (r) return "R1";
        if (h) return "R6";
        if (l) return d ? "R3" : "R2";
        return d ? "R5" : "R4";
    endfunction

    // Drive while the clock is low, check after the rising and after the falling edge
    task automatic cyc(input logic r, input logic d, input logic l, input logic h,
                       input logic su, input logic sd);
        logic [N-1:0] nx;
        rst = r; dir_dn = d; load = l; hold = h; ser_up_i = su; ser_dn_i = sd;
        if (r)      nx = '0;
        else if (h) nx = model;
        else if (!d) nx = {model[N-2:0], (l ? su : model[N-1])};
        else         nx = {(l ? sd : model[0]), model[N-1:1]};
        @(posedge clk); #2;
        chk({tag_of(r, d, l, h), "/R8 stages"}, stages_o, nx);
        if (vis_ok) chk("R7 taps before fall", {30'd0, lo_tap_o, hi_tap_o},
                        {30'd0, lo_vis, hi_vis});
        model = nx;
        @(negedge clk); #2;
        lo_vis = model[0]; hi_vis = model[N-1]; vis_ok = 1'b1;
        chk(r ? "R1 taps after fall" : "R7 taps after fall",
            {30'd0, lo_tap_o, hi_tap_o}, {30'd0, lo_vis, hi_vis});
    endtask

    function automatic logic [15:0] lfsr_next(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    initial begin
        #(200000 * 10);
        total++; bad++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] pat;
        rst = 1'b1; dir_dn = 1'b0; load = 1'b1; hold = 1'b0;
        ser_up_i = 1'b0; ser_dn_i = 1'b0; model = '0;
        @(negedge clk); #1;
        // R1: reset state
        cyc(1, 0, 1, 0, 0, 0);
        cyc(1, 0, 1, 0, 0, 0);

        // Fill with ones from the low end (R2), then from the high end (R3)
        for (int k = 0; k < 20; k++) cyc(0, 0, 1, 0, 1, 0);
        for (int k = 0; k < 5; k++)  cyc(0, 1, 1, 0, 0, 1);
        // R4 and R5: serial inputs disagree with the wrapped bit
        for (int k = 0; k < 40; k++) cyc(0, 0, 0, 0, ~model[N-1], 1);
        for (int k = 0; k < 40; k++) cyc(0, 1, 0, 0, 1, ~model[0]);
        // R6: hold with every other control pattern
        for (int k = 0; k < 16; k++) cyc(0, k[0], k[1], 1, k[2], k[3]);
        // R1: reset wins over hold
        cyc(1, 0, 1, 1, 1, 1);
        chk("R1 reset beats hold", stages_o, '0);

        // Sweep: every control and serial-input combination, data from an LFSR
        for (int n = 0; n < 3000; n++) begin
            lfsr = lfsr_next(lfsr);
            cyc((n % 211) == 105, lfsr[3] ^ n[6], n[0] | n[5], n[1] & n[2] & n[3],
                lfsr[0], lfsr[7]);
        end

        // R10: stack order, 16 pushes then 16 pops
        cyc(1, 0, 1, 0, 0, 0);
        pat = 16'hB3C5;
        for (int k = 0; k < 16; k++) cyc(0, 0, 1, 0, pat[k], 0);
        for (int j = 0; j < 16; j++) begin
            chk("R10 pop order", {31'd0, lo_tap_o}, {31'd0, pat[15-j]});
            cyc(0, 1, 1, 0, 0, 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule